// File: doc/BRIEF.md
# Full-Period Byte Pseudo-Random Source

This block generates pseudo-random test data from an 8-bit linear feedback shift register. A plain shift register of that kind can never produce the all-zeros byte, because from zero it would stay at zero. Here a small correction term on the feedback splices the zero state into the cycle. The register therefore walks through all 256 byte values in a scrambled order and then starts again. It cannot get stuck.

Each pulse on `step` advances the generator. In byte mode one step advances it once and presents the new byte. In word mode one step advances it twice in the same cycle and presents both bytes as one 16-bit word, which suits filling register-pair test patterns. Because the generator never repeats within its period, consecutive words differ. A seed can be written at any time through `load`/`seed`. Width, feedback taps, the zero-splice option and the reset seed are parameters.

Top module: `prng_fullcycle`

## Requirements
- R1: After reset `data` is 0, `valid` is 0 and the internal state is `RST_SEED` (default 8'h01), so the first byte-mode step yields 8'h02.
- R2: A step taken without a load makes `valid` high for exactly the following cycle, with `data` updated in that same cycle.
- R3: One advance maps state s to {s[6:0], s[7]^s[5]^s[4]^s[3]^(s[6:0]==0)}. These are the taps of x^8+x^6+x^5+x^4+1 with the feedback inverted when the low seven bits are zero.
- R4: From any seed, 256 consecutive advances visit all 256 byte values once each, including 8'h00, and return to the seed.
- R5: In byte mode (`mode16`=0) a step presents `data` = {8'h00, next(s)} and the state becomes next(s).
- R6: In word mode (`mode16`=1) a step presents `data` = {next(s), next(next(s))}, with the first byte in bits 15:8, and the state becomes next(next(s)).
- R7: Two consecutive word-mode steps yield different words.
- R8: `load` writes `seed` into the state and takes priority over a step in the same cycle. That cycle leaves `valid` low and `data` unchanged.
- R9: In a cycle with neither step nor load, `data` and the state hold and `valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Write `seed` into the state |
| seed | input | 8 | Seed value |
| step | input | 1 | Advance strobe |
| mode16 | input | 1 | 0: one byte per step, 1: two-byte word per step |
| data | output | 16 | Last presented byte or word |
| valid | output | 1 | High for one cycle after each step |

## Verification
The bench targets the zero splice. It seeds at 8'h00 and at 8'h80, the two states around the splice, and also at random seeds. It then demands exactly 256 distinct values and a return to the seed. A design without the correction would lock at zero or skip it, and its count would come up short. Word mode is checked for byte order and double advance: a swapped concatenation, or only one advance per step, shows up against the model at once. Load arriving together with a step checks priority, where a wrong design would advance past the seed or raise `valid`. Idle cycles check that nothing drifts.

// File: rtl/prng_pkg.sv
package prng_pkg;
   typedef enum logic {
      ADV_ONCE  = 1'b0,
      ADV_TWICE = 1'b1
   } adv_mode_e;
endpackage

// File: rtl/prng_stage.sv
module prng_stage #(
   parameter int          W          = 8,
   parameter logic [W-1:0] TAPS      = 8'hB8,
   parameter bit          FULL_CYCLE = 1'b1
) (
   input  logic [W-1:0] cur,
   output logic [W-1:0] nxt
);
   logic fb_lin;
   logic fb;

   assign fb_lin = ^(cur & TAPS);

   generate
      if (FULL_CYCLE) begin : g_splice
         logic low_zero;
         assign low_zero = (cur[W-2:0] == '0);
         assign fb = fb_lin ^ low_zero;
      end else begin : g_plain
         assign fb = fb_lin;
      end
   endgenerate

   assign nxt = {cur[W-2:0], fb};
endmodule

// File: rtl/prng_core.sv
module prng_core
   import prng_pkg::*;
#(
   parameter int          W          = 8,
   parameter logic [W-1:0] TAPS      = 8'hB8,
   parameter bit          FULL_CYCLE = 1'b1,
   parameter logic [W-1:0] RST_SEED  = 8'h01
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         adv,
   input  adv_mode_e    mode,
   output logic [W-1:0] nxt1,
   output logic [W-1:0] nxt2
);
   localparam int NSTG = 2;

   logic [W-1:0] state_q;
   logic [W-1:0] chain [NSTG+1];

   assign chain[0] = state_q;

   generate
      for (genvar i = 0; i < NSTG; i++) begin : g_stg
         prng_stage #(.W(W), .TAPS(TAPS), .FULL_CYCLE(FULL_CYCLE)) u_stg (
            .cur(chain[i]),
            .nxt(chain[i+1])
         );
      end
   endgenerate

   assign nxt1 = chain[1];
   assign nxt2 = chain[2];

   always_ff @(posedge clk) begin
      if (!rst_n)
         state_q <= RST_SEED;
      else if (load)
         state_q <= seed;
      else if (adv)
         state_q <= (mode == ADV_TWICE) ? chain[2] : chain[1];
   end
endmodule

// File: rtl/prng_outreg.sv
module prng_outreg
   import prng_pkg::*;
#(
   parameter int W = 8,
   localparam int DW = 2 * W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  adv_mode_e     mode,
   input  logic [W-1:0]  nxt1,
   input  logic [W-1:0]  nxt2,
   output logic [DW-1:0] data,
   output logic          valid
);
   logic [DW-1:0] word_d;

   always_comb begin
      if (mode == ADV_TWICE)
         word_d = {nxt1, nxt2};
      else
         word_d = {{W{1'b0}}, nxt1};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= adv;
         if (adv)
            data <= word_d;
      end
   end
endmodule

// File: rtl/prng_fullcycle.sv
module prng_fullcycle
   import prng_pkg::*;
#(
   parameter int          W          = 8,
   parameter logic [W-1:0] TAPS      = 8'hB8,
   parameter bit          FULL_CYCLE = 1'b1,
   parameter logic [W-1:0] RST_SEED  = 8'h01
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [W-1:0]   seed,
   input  logic           step,
   input  logic           mode16,
   output logic [2*W-1:0] data,
   output logic           valid
);
   initial begin
      if (W < 3 || W > 32)
         $error("prng_fullcycle: W must be 3..32");
      if (!TAPS[W-1])
         $error("prng_fullcycle: top tap bit must be set");
   end

   logic         adv;
   adv_mode_e    mode;
   logic [W-1:0] nxt1;
   logic [W-1:0] nxt2;

   assign adv  = step & ~load;
   assign mode = mode16 ? ADV_TWICE : ADV_ONCE;

   prng_core #(.W(W), .TAPS(TAPS), .FULL_CYCLE(FULL_CYCLE), .RST_SEED(RST_SEED)) u_core (
      .clk(clk), .rst_n(rst_n), .load(load), .seed(seed),
      .adv(adv), .mode(mode), .nxt1(nxt1), .nxt2(nxt2)
   );

   prng_outreg #(.W(W)) u_out (
      .clk(clk), .rst_n(rst_n), .adv(adv), .mode(mode),
      .nxt1(nxt1), .nxt2(nxt2), .data(data), .valid(valid)
   );
endmodule

// File: rtl/prng_fullcycle_chk.sv
module prng_fullcycle_chk #(
   parameter int          W          = 8,
   parameter logic [W-1:0] TAPS      = 8'hB8,
   parameter bit          FULL_CYCLE = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           load,
   input logic           step,
   input logic           mode16,
   input logic [2*W-1:0] data,
   input logic           valid
);
   function automatic logic [W-1:0] adv1(input logic [W-1:0] s);
      logic f;
      f = ^(s & TAPS);
      if (FULL_CYCLE && s[W-2:0] == '0) f = ~f;
      return {s[W-2:0], f};
   endfunction

   // R2: valid only after an accepted step
   a_r2_valid_src: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(step && !load));

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> valid);

   // R8/R9: no accepted step -> valid low, data held
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(step && !load) |=> (!valid && $stable(data)));

   // R3/R5: byte step continues from the presented state
   a_r5_byte_chain: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && step && !load && !mode16) |=>
         (data == {{W{1'b0}}, adv1($past(data[W-1:0]))}));

   // R6: word step advances twice from the presented state
   a_r6_word_chain: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && step && !load && mode16) |=>
         (data[2*W-1:W] == adv1($past(data[W-1:0])) &&
          data[W-1:0] == adv1(data[2*W-1:W])));
endmodule

bind prng_fullcycle prng_fullcycle_chk #(.W(W), .TAPS(TAPS), .FULL_CYCLE(FULL_CYCLE)) u_chk (
   .clk(clk), .rst_n(rst_n), .load(load), .step(step),
   .mode16(mode16), .data(data), .valid(valid)
);

// File: tb/sim_prng_fullcycle.sv
module sim_prng_fullcycle;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [7:0]  seed = 8'h00;
   logic        step = 1'b0;
   logic        mode16 = 1'b0;
   logic [15:0] data;
   logic        valid;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   logic [7:0] ms;

   always #10 clk = ~clk;

   prng_fullcycle u0 (
      .clk(clk), .rst_n(rst_n), .load(load), .seed(seed),
      .step(step), .mode16(mode16), .data(data), .valid(valid)
   );

   function automatic logic [7:0] nx(input logic [7:0] s);
      return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3] ^ (s[6:0] == 7'd0)};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_step(input bit m);
      @(negedge clk); step = 1'b1; mode16 = m;
      @(negedge clk); step = 1'b0;
   endtask

   task automatic do_load(input logic [7:0] v);
      @(negedge clk); load = 1'b1; seed = v;
      @(negedge clk); load = 1'b0;
      ms = v;
   endtask

   task automatic period_test(input logic [7:0] s0);
      bit seen [256];
      int distinct = 0;
      bit ok_seq = 1;
      logic [7:0] e;
      for (int i = 0; i < 256; i++) seen[i] = 0;
      do_load(s0);
      for (int i = 0; i < 256; i++) begin
         do_step(1'b0);
         e = nx(ms);
         ms = e;
         if (data != {8'h00, e} || !valid) begin
            ok_seq = 0;
            chk(0, "R5 byte step", {15'd0, valid, data}, {16'd1, 8'h00, e});
         end
         if (!seen[data[7:0]]) begin
            seen[data[7:0]] = 1;
            distinct++;
         end
      end
      chk(ok_seq, "R3 sequence", 0, 0);
      chk(distinct == 256, "R4 distinct count", distinct, 256);
      chk(seen[0], "R4 zero reached", 0, 1);
      chk(data[7:0] == s0, "R4 returns to seed", data, s0);
   endtask

   initial begin
      logic [15:0] w_prev;
      logic [7:0]  a;
      logic [7:0]  b;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      chk(data == 16'h0 && valid == 1'b0, "R1 reset outputs", {15'd0, valid, data}, 0);
      rst_n = 1'b1;
      do_step(1'b0);
      chk(data == 16'h0002, "R1 first step from reset seed", data, 16'h0002);
      chk(valid, "R2 valid after step", valid, 1);
      @(negedge clk);
      chk(!valid, "R2 valid one cycle", valid, 0);
      chk(data == 16'h0002, "R9 idle hold", data, 16'h0002);

      // spliced neighbours and random seeds
      period_test(8'h00);
      period_test(8'h80);
      for (int k = 0; k < 3; k++) period_test(8'($urandom));

      // R3 splice points directly
      do_load(8'h80); do_step(1'b0);
      chk(data[7:0] == 8'h00, "R3 0x80 to zero", data, 8'h00);
      do_step(1'b0);
      chk(data[7:0] == 8'h01, "R3 zero to 0x01", data, 8'h01);

      // R6 / R7 word mode, random seeds
      for (int k = 0; k < 20; k++) begin
         do_load(8'($urandom));
         w_prev = 16'hxxxx;
         for (int j = 0; j < 4; j++) begin
            a = nx(ms); b = nx(a); ms = b;
            do_step(1'b1);
            chk(data == {a, b} && valid, "R6 word step", data, {a, b});
            if (j > 0) chk(data != w_prev, "R7 consecutive words differ", data, w_prev);
            w_prev = data;
         end
         if (($urandom % 2) == 1) begin
            a = nx(ms); ms = a;
            do_step(1'b0);
            chk(data == {8'h00, a}, "R5 byte after word", data, {8'h00, a});
         end
      end

      // R8 load priority over step
      w_prev = data;
      @(negedge clk); load = 1'b1; seed = 8'h3C; step = 1'b1; mode16 = 1'b0;
      @(negedge clk); load = 1'b0; step = 1'b0;
      chk(!valid, "R8 valid low on load", valid, 0);
      chk(data == w_prev, "R8 data held on load", data, w_prev);
      ms = 8'h3C;
      do_step(1'b0);
      chk(data == {8'h00, nx(8'h3C)}, "R8 seed loaded, not advanced", data, {8'h00, nx(8'h3C)});

      // R9 idle cycles keep state
      w_prev = data; ms = data[7:0];
      repeat (5) @(negedge clk);
      chk(data == w_prev && !valid, "R9 idle data", data, w_prev);
      do_step(1'b0);
      chk(data[7:0] == nx(ms), "R9 state held over idle", data, nx(ms));

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule